// File: doc/BRIEF.md
# Tap Gesture Detector

This block watches a stream of three-axis acceleration samples and recognises short knocks on the device. A knock, or tap, is an excursion of any enabled axis above a programmable magnitude threshold that falls back below it before a programmable maximum duration has passed. After a tap the block ignores a programmable latency period. It then opens a programmable window in which a second tap may start. If one does, and it also qualifies, a double-tap event is reported.

Timing is counted in two external tick strobes: a fine tick with a 625 us period for the duration limit, and a coarse tick with a 1.25 ms period for latency and window. The whole block therefore runs on one fast clock. Samples arrive on a valid strobe. The block emits one-cycle pulses for single and double taps and keeps a three-bit record of which axes started the most recent reported tap.

Top module: `tap_detector`

## Requirements
- R1: An axis is above threshold when it is enabled and the magnitude of its two's complement sample is strictly greater than the threshold code times 16 in sample units. A magnitude equal to that value does not count.
- R2: `single_o` pulses for one cycle, in the cycle after a below-threshold sample that ends an excursion, provided fewer than `dur_i` fine ticks occurred during the excursion.
- R3: When the `dur_i`-th fine tick arrives during an excursion, the excursion is discarded with no pulse. A new tap can start only after a below-threshold sample has been seen.
- R4: While `dur_i` is 0, neither `single_o` nor `double_o` ever pulses.
- R5: A second tap that starts after `latent_i` coarse ticks, before `window_i` further coarse ticks, and that qualifies under R2, produces a one-cycle `double_o` pulse in the cycle after its ending sample. It does not also produce `single_o`.
- R6: With suppression off, an above-threshold sample during the latency period has no effect. When the window expires without a second tap, the block returns to idle, and the next tap is reported as a single tap.
- R7: If `latent_i` or `window_i` is 0, no double tap is reported, and every qualifying tap is reported as a single tap.
- R8: With `suppress_i` set, an above-threshold sample during the latency period cancels the pending double tap. Detection resumes after a below-threshold sample.
- R9: A sample whose only excursions are on disabled axes (`axis_en_i` bit 0) starts no tap.
- R10: `src_o` (bit 2 = x, bit 1 = y, bit 0 = z) is loaded at each reported event with the enabled axes that were above threshold on the sample that started that tap. Between events it holds its value.
- R11: `single_o` and `double_o` are never high together, and each is high for at most one cycle at a time.
- R12: After reset both pulses are low and `src_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_vld_i | input | 1 | New sample present on the axis inputs |
| acc_x_i | input | DW | X-axis sample, two's complement |
| acc_y_i | input | DW | Y-axis sample, two's complement |
| acc_z_i | input | DW | Z-axis sample, two's complement |
| axis_en_i | input | 3 | Axis participation, bit 2 = x, bit 1 = y, bit 0 = z |
| thresh_i | input | TW | Magnitude threshold code |
| dur_i | input | TW | Maximum excursion length in fine ticks; 0 disables detection |
| latent_i | input | TW | Dead time after a tap in coarse ticks |
| window_i | input | TW | Second-tap window in coarse ticks |
| suppress_i | input | 1 | Cancel a double tap on activity during the latency period |
| tick_fine_i | input | 1 | 625 us time-base strobe |
| tick_coarse_i | input | 1 | 1.25 ms time-base strobe |
| single_o | output | 1 | Single-tap event pulse |
| double_o | output | 1 | Double-tap event pulse |
| src_o | output | 3 | Axes that started the last reported tap |

## Verification
The bench builds the block with its default parameters: 16-bit samples, 8-bit timing and threshold codes, and a threshold scale of 16 sample units. These values let it reach the extremes directly. It applies the most negative sample, whose magnitude needs the extra comparator bit, and the top threshold code, where a value one unit above the scaled limit must count. It also uses duration, latency and window settings of two or three ticks. Each boundary of the duration, latency and window timing then sits one tick either side of a short, exactly known count.

// File: rtl/tap_pkg.sv
package tap_pkg;
  localparam int unsigned AXES = 3;

  typedef enum logic [2:0] {
    S_IDLE,
    S_TAP1,
    S_LAT,
    S_WIN,
    S_TAP2,
    S_REARM
  } tap_state_e;
endpackage

// File: rtl/tap_mag.sv
module tap_mag #(
  parameter int unsigned DW    = 16,
  parameter int unsigned TW    = 8,
  parameter int unsigned SHIFT = 4,
  parameter int unsigned AXES  = tap_pkg::AXES
) (
  input  logic [AXES-1:0][DW-1:0] acc_i,
  input  logic [AXES-1:0]         en_i,
  input  logic [TW-1:0]           thr_i,
  output logic [AXES-1:0]         hit_o
);
  localparam int unsigned LW = TW + SHIFT;
  localparam int unsigned CW = (DW + 1 > LW) ? DW + 1 : LW;

  logic [CW-1:0] lim;
  assign lim = CW'({thr_i, {SHIFT{1'b0}}});

  for (genvar g = 0; g < AXES; g++) begin : g_axis
    logic [DW-1:0] raw;
    logic [CW-1:0] mag;
    assign raw = acc_i[g];
    // magnitude needs one extra bit for the most negative code
    assign mag = raw[DW-1] ? (CW'(~raw) + CW'(1)) : CW'(raw);
    assign hit_o[g] = en_i[g] && (mag > lim);
  end
endmodule

// File: rtl/tap_timer.sv
module tap_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic [TW-1:0] lim_i,
  output logic          exp_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + TW'(1);
  end

  // expires on the lim_i-th tick since the last clear
  assign exp_o = tick_i && (cnt_q == lim_i - TW'(1));
endmodule

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
#(
  parameter int unsigned TW   = 8,
  parameter int unsigned AXES = tap_pkg::AXES
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sample_vld_i,
  input  logic [AXES-1:0] hit_i,
  input  logic [TW-1:0]   dur_i,
  input  logic [TW-1:0]   latent_i,
  input  logic [TW-1:0]   window_i,
  input  logic            suppress_i,
  input  logic            tmr_exp_i,
  output logic            tmr_clr_o,
  output logic            tmr_coarse_o,
  output logic [TW-1:0]   tmr_lim_o,
  output logic            single_o,
  output logic            double_o,
  output logic [AXES-1:0] src_o
);
  tap_state_e state_q, state_d;
  logic [AXES-1:0] pend_q, src_q;
  logic single_q, double_q;
  logic above, below, dbl_en, qual1, qual2, cap;

  assign above  = sample_vld_i && (|hit_i);
  assign below  = sample_vld_i && !(|hit_i);
  assign dbl_en = (latent_i != '0) && (window_i != '0);

  always_comb begin
    state_d = state_q;
    qual1   = 1'b0;
    qual2   = 1'b0;
    cap     = 1'b0;
    unique case (state_q)
      S_IDLE: if (above) begin
        state_d = S_TAP1;
        cap     = 1'b1;
      end
      S_TAP1: begin
        if (tmr_exp_i) state_d = S_REARM;
        else if (below) begin
          qual1   = 1'b1;
          state_d = dbl_en ? S_LAT : S_IDLE;
        end
      end
      S_LAT: begin
        if (tmr_exp_i) state_d = S_WIN;
        else if (above && suppress_i) state_d = S_REARM;
      end
      S_WIN: begin
        if (tmr_exp_i) state_d = S_IDLE;
        else if (above) begin
          state_d = S_TAP2;
          cap     = 1'b1;
        end
      end
      S_TAP2: begin
        if (tmr_exp_i) state_d = S_REARM;
        else if (below) begin
          qual2   = 1'b1;
          state_d = S_IDLE;
        end
      end
      S_REARM: if (below) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
    if (dur_i == '0) begin
      state_d = S_IDLE;
      qual1   = 1'b0;
      qual2   = 1'b0;
      cap     = 1'b0;
    end
  end

  assign tmr_clr_o    = (state_d != state_q);
  assign tmr_coarse_o = (state_q == S_LAT) || (state_q == S_WIN);

  always_comb begin
    unique case (state_q)
      S_LAT:   tmr_lim_o = latent_i;
      S_WIN:   tmr_lim_o = window_i;
      default: tmr_lim_o = dur_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      pend_q   <= '0;
      src_q    <= '0;
      single_q <= 1'b0;
      double_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      single_q <= qual1;
      double_q <= qual2;
      if (cap) pend_q <= hit_i;
      if (qual1 || qual2) src_q <= pend_q;
    end
  end

  assign single_o = single_q;
  assign double_o = double_q;
  assign src_o    = src_q;
endmodule

// File: rtl/tap_detector.sv
module tap_detector
  import tap_pkg::*;
#(
  parameter int unsigned DW    = 16,
  parameter int unsigned TW    = 8,
  parameter int unsigned SHIFT = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sample_vld_i,
  input  logic [DW-1:0] acc_x_i,
  input  logic [DW-1:0] acc_y_i,
  input  logic [DW-1:0] acc_z_i,
  input  logic [2:0]    axis_en_i,
  input  logic [TW-1:0] thresh_i,
  input  logic [TW-1:0] dur_i,
  input  logic [TW-1:0] latent_i,
  input  logic [TW-1:0] window_i,
  input  logic          suppress_i,
  input  logic          tick_fine_i,
  input  logic          tick_coarse_i,
  output logic          single_o,
  output logic          double_o,
  output logic [2:0]    src_o
);
  logic [AXES-1:0][DW-1:0] acc;
  logic [AXES-1:0] hit;
  logic tmr_clr, tmr_coarse, tmr_exp, tmr_tick;
  logic [TW-1:0] tmr_lim;

  assign acc = {acc_x_i, acc_y_i, acc_z_i};

  tap_mag #(.DW(DW), .TW(TW), .SHIFT(SHIFT), .AXES(AXES)) u_mag (
    .acc_i (acc),
    .en_i  (axis_en_i),
    .thr_i (thresh_i),
    .hit_o (hit)
  );

  assign tmr_tick = tmr_coarse ? tick_coarse_i : tick_fine_i;

  tap_timer #(.TW(TW)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (tmr_clr),
    .tick_i (tmr_tick),
    .lim_i  (tmr_lim),
    .exp_o  (tmr_exp)
  );

  tap_fsm #(.TW(TW), .AXES(AXES)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sample_vld_i (sample_vld_i),
    .hit_i        (hit),
    .dur_i        (dur_i),
    .latent_i     (latent_i),
    .window_i     (window_i),
    .suppress_i   (suppress_i),
    .tmr_exp_i    (tmr_exp),
    .tmr_clr_o    (tmr_clr),
    .tmr_coarse_o (tmr_coarse),
    .tmr_lim_o    (tmr_lim),
    .single_o     (single_o),
    .double_o     (double_o),
    .src_o        (src_o)
  );
endmodule

// File: rtl/tap_detector_chk.sv
module tap_detector_chk #(
  parameter int unsigned TW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [TW-1:0] dur_i,
  input logic          single_o,
  input logic          double_o,
  input logic [2:0]    src_o
);
  p_single_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    single_o |=> !single_o);
  p_double_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    double_o |=> !double_o);
  p_exclusive_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({single_o, double_o}));
  p_dur_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dur_i == '0) |=> (!single_o && !double_o));
  p_src_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!single_o && !double_o) |-> $stable(src_o));
  p_src_axis_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (single_o || double_o) |-> (src_o != 3'b000));
endmodule

bind tap_detector tap_detector_chk #(.TW(TW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .dur_i    (dur_i),
  .single_o (single_o),
  .double_o (double_o),
  .src_o    (src_o)
);

// File: tb/sim_tap_detector.sv
`timescale 1ns/1ps
module sim_tap_detector;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic vld = 1'b0;
  logic signed [15:0] ax = '0, ay = '0, az = '0;
  logic [2:0] en = 3'b111;
  logic [7:0] thr = 8'd10, dur = 8'd3, lat = 8'd0, win = 8'd0;
  logic sup = 1'b0, tf = 1'b0, tc = 1'b0;
  logic single_o, double_o;
  logic [2:0] src_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tap_detector u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sample_vld_i(vld),
    .acc_x_i(ax), .acc_y_i(ay), .acc_z_i(az), .axis_en_i(en),
    .thresh_i(thr), .dur_i(dur), .latent_i(lat), .window_i(win),
    .suppress_i(sup), .tick_fine_i(tf), .tick_coarse_i(tc),
    .single_o(single_o), .double_o(double_o), .src_o(src_o)
  );

  typedef struct packed {
    logic signed [15:0] x, y, z;
    logic [2:0] en;
    logic [7:0] thr;
    logic [3:0] tk;
    logic       es;
    logic [2:0] esrc;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{16'sd161,    16'sd0,    16'sd0,    3'b111, 8'd10,  4'd2, 1'b1, 3'b100},
    '{16'sd160,    16'sd0,    16'sd0,    3'b111, 8'd10,  4'd1, 1'b0, 3'b100},
    '{16'sd0,      -16'sd161, 16'sd0,    3'b111, 8'd10,  4'd2, 1'b1, 3'b010},
    '{16'sd200,    16'sd0,    16'sd300,  3'b011, 8'd10,  4'd1, 1'b1, 3'b001},
    '{16'sd300,    16'sd0,    16'sd0,    3'b011, 8'd10,  4'd1, 1'b0, 3'b001},
    '{16'sd500,    16'sd500,  16'sd500,  3'b111, 8'd10,  4'd3, 1'b0, 3'b001},
    '{-16'sd32768, 16'sd0,    16'sd0,    3'b111, 8'd255, 4'd0, 1'b1, 3'b100},
    '{16'sd0,      16'sd0,    16'sd4081, 3'b111, 8'd255, 4'd2, 1'b1, 3'b001}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic smp(input logic signed [15:0] x, y, z);
    @(negedge clk); vld = 1'b1; ax = x; ay = y; az = z;
    @(negedge clk); vld = 1'b0; ax = '0; ay = '0; az = '0;
  endtask

  task automatic ftk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tf = 1'b1;
      @(negedge clk); tf = 1'b0;
    end
  endtask

  task automatic ctk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tc = 1'b1;
      @(negedge clk); tc = 1'b0;
    end
  endtask

  // one fine tick inside the excursion, then the ending sample
  task automatic tap(input logic signed [15:0] x, y, z);
    smp(x, y, z);
    ftk(1);
    smp(0, 0, 0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 single", single_o, 0);
    chk("R12 double", double_o, 0);
    chk("R12 src", src_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R9 R10 table, double tap off
    for (int v = 0; v < 8; v++) begin
      en = VEC[v].en; thr = VEC[v].thr;
      smp(VEC[v].x, VEC[v].y, VEC[v].z);
      ftk(int'(VEC[v].tk));
      smp(0, 0, 0);
      chk($sformatf("R1/R2 vec%0d single", v), single_o, VEC[v].es);
      chk($sformatf("R10 vec%0d src", v), src_o, VEC[v].esrc);
    end
    en = 3'b111; thr = 8'd10;

    // R3: no re-arm until a below sample
    smp(500, 0, 0); ftk(3);
    smp(500, 0, 0); ftk(1);
    smp(0, 0, 0);
    chk("R3 no rearm", single_o, 0);
    tap(500, 0, 0);
    chk("R3 rearmed", single_o, 1);

    // R4
    dur = 8'd0;
    smp(500, 0, 0); smp(0, 0, 0);
    chk("R4 disabled", single_o, 0);
    dur = 8'd3;

    // R5 double tap
    lat = 8'd2; win = 8'd3;
    tap(500, 0, 0);
    chk("R5 first single", single_o, 1);
    ctk(2);
    tap(0, 500, 0);
    chk("R5 double", double_o, 1);
    chk("R5 no single", single_o, 0);
    chk("R10 double src", src_o, 3'b010);

    // R6: activity in latency ignored without suppress
    tap(500, 0, 0);
    ctk(1);
    smp(500, 0, 0); smp(0, 0, 0);
    ctk(1);
    tap(0, 0, 500);
    chk("R6 latency ignored", double_o, 1);

    // R6: window expiry returns to idle
    tap(500, 0, 0);
    ctk(5);
    tap(500, 0, 0);
    chk("R6 after expiry single", single_o, 1);
    chk("R6 after expiry no double", double_o, 0);
    ctk(6);

    // R8 suppression
    sup = 1'b1;
    tap(500, 0, 0);
    ctk(1);
    smp(500, 0, 0); smp(0, 0, 0);
    ctk(1);
    tap(500, 0, 0);
    chk("R8 suppressed single", single_o, 1);
    chk("R8 suppressed no double", double_o, 0);
    ctk(6);
    sup = 1'b0;

    // R7 zero latency or window
    lat = 8'd0;
    tap(500, 0, 0);
    tap(500, 0, 0);
    chk("R7 latent0 single", single_o, 1);
    lat = 8'd2; win = 8'd0;
    tap(500, 0, 0);
    ctk(2);
    tap(500, 0, 0);
    chk("R7 window0 single", single_o, 1);
    chk("R7 window0 no double", double_o, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule